// File: doc/BRIEF.md
# Single-Precision Fused Multiply-Subtract Core

This unit computes `z - (x * y)` on three IEEE754 single-precision operands without any intermediate rounding. It handles every special operand in a fixed priority order: signalling and quiet NaNs, infinities, zeros and denormals. A special case comes out as a finished 32-bit word. Any other case comes out as an unrounded result: a sign, an unbiased exponent and a 27-bit significand. The significand has its hidden bit at bit 26 and guard, round and sticky bits at bits 2..0. A separate formatting stage rounds and packs that result. The formatting stage also detects overflow and underflow.

The subtraction runs on the adder. The product's sign is inverted and the product is then added to `z`. The 24x24 significand product is built from four 16x16 partial products of the left-justified operands. Its lower 32 bits fold into a single sticky bit. Alignment shifts the operand with the smaller exponent right and keeps the bits it shifts out as sticky. After a subtraction, a leading-zero shift puts the hidden bit back at bit 26.

The unit has one register stage. A strobe on `in_valid` gives a result on the outputs, with `out_valid` high, on the next clock edge. `out_final` marks a result that must bypass rounding.

Top module: `fms_core`

## Requirements
- R1: `out_valid` is low during and right after reset. After reset it equals the value `in_valid` had at the previous rising clock edge, so each result appears one cycle after its strobe.
- R2: When `z` is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), that rule wins over every other. The result is `z` with bit 22 set, with `out_final` and `out_invalid` both high.
- R3: When `z` is not a signalling NaN, NaNs among `x` and `y` are resolved in this order. First, `y` signalling while `x` is not gives quieted `y`. Second, `x` signalling gives quieted `x`. Third, `y` quiet while `x` is not a NaN gives `y`. Fourth, `x` quiet gives `x`. Quieting sets bit 22. `out_invalid` is high only for the two signalling cases.
- R4: When `x` and `y` are not NaNs and `z` is a quiet NaN (bit 22 set), the result is `z` unchanged, with `out_invalid` low. This holds even for infinity times zero.
- R5: Infinity times zero, with `z` not a NaN, gives 0x7FC00000 with `out_invalid` high.
- R6: Infinity times a nonzero value, with `z` not a NaN, gives an infinity whose sign is the XOR of the signs of `x` and `y`.
- R7: A product with a zero factor and no NaN or infinite factor gives the `z` word unchanged. So does an infinite `z` with a finite, nonzero product.
- R8: A denormal operand is normalised before the arithmetic and counts as its exact value.
- R9: For any other input, `out_final` is low and `out_sig[26]` is high. The value `(-1)^out_sign * out_sig * 2^(out_exp-26)` equals `z - x*y` to within 2^-22 of the larger of `|z|` and `|x*y|`.
- R10: When `z` and the negated product have the same sign, their magnitudes are added. A carry out of bit 26 shifts the sum right by one, keeps the sticky bit and increments the exponent.
- R11: An exact zero difference gives a final word. That word is 0x80000000 when `rmode` is 2'b11 (round toward minus infinity) and 0x00000000 for any other `rmode` value.
- R12: An alignment shift of 27 or more positions leaves only the sticky bit of the shifted operand. For example, 1.0 - 2^-100 gives sign 0, exponent -1 and significand 0x7FFFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| opnd_z | input | 32 | Minuend `z` |
| opnd_x | input | 32 | First product factor `x` |
| opnd_y | input | 32 | Second product factor `y` |
| rmode | input | 2 | Rounding mode; 2'b11 selects toward minus infinity |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_final | output | 1 | Result is the finished word on `out_word`; skip rounding |
| out_word | output | 32 | Finished word when `out_final` is high, else 0 |
| out_invalid | output | 1 | Invalid-operation flag |
| out_sign | output | 1 | Sign of the unrounded result |
| out_exp | output | 10 | Unbiased exponent of the unrounded result, two's complement |
| out_sig | output | 27 | Unrounded significand: hidden bit 26, guard/round/sticky in bits 2..0 |

## Verification
An error in the special-case priority appears at once as the wrong word or the wrong invalid flag. It is visible in the same cycle as `out_valid`, for a specific pair of operand classes. The operand sweep crosses every pair of classes, so each such error is reached.

An error in the product, the alignment or the normalisation datapath does not give a wrong word. It gives a significand or exponent whose value is off. It may also leave bit 26 clear or let a lost bit drop out of sticky. The value comparison catches these cases, and so do the exact checks on carry, cancellation and saturated shifts.

// File: rtl/fms_pkg.sv
package fms_pkg;
  localparam int WORD_W = 32;
  localparam int FRAC_W = 23;
  localparam int EF_W   = 8;
  localparam int MAN_W  = FRAC_W + 1;
  localparam int EXT_W  = MAN_W + 3;
  localparam int XE_W   = 10;
  localparam int BIAS   = (1 << (EF_W - 1)) - 1;
  localparam logic [WORD_W-1:0] DEF_NAN = 32'h7FC0_0000;

  typedef enum logic [2:0] {
    C_ZERO, C_NORM, C_DNORM, C_INF, C_QNAN, C_SNAN
  } fcls_e;

  function automatic logic [4:0] lzc_man(input logic [MAN_W-1:0] v);
    lzc_man = 5'(MAN_W);
    for (int i = 0; i < MAN_W; i++)
      if (v[i]) lzc_man = 5'(MAN_W - 1 - i);
  endfunction

  function automatic logic [4:0] lzc_ext(input logic [EXT_W-1:0] v);
    lzc_ext = 5'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) lzc_ext = 5'(EXT_W - 1 - i);
  endfunction
endpackage

// File: rtl/fms_unpack.sv
module fms_unpack
  import fms_pkg::*;
(
  input  logic [WORD_W-1:0]       word,
  output fcls_e                   cls,
  output logic                    sgn,
  output logic signed [XE_W-1:0]  ex,
  output logic [MAN_W-1:0]        man
);
  logic [EF_W-1:0]   ef;
  logic [FRAC_W-1:0] fr;
  logic [4:0]        lz;

  assign ef  = word[WORD_W-2 -: EF_W];
  assign fr  = word[FRAC_W-1:0];
  assign sgn = word[WORD_W-1];

  always_comb begin
    lz  = lzc_man({1'b0, fr});
    cls = C_NORM;
    man = {1'b1, fr};
    ex  = XE_W'(int'(ef) - BIAS);
    if (ef == '1) begin
      man = '0;
      ex  = '0;
      if (fr == '0)        cls = C_INF;
      else if (fr[FRAC_W-1]) cls = C_QNAN;
      else                 cls = C_SNAN;
    end else if (ef == '0) begin
      if (fr == '0) begin
        cls = C_ZERO;
        man = '0;
        ex  = '0;
      end else begin
        cls = C_DNORM;
        man = {1'b0, fr} << lz;
        ex  = XE_W'(1 - BIAS - int'(lz));
      end
    end
  end
endmodule

// File: rtl/fms_special.sv
module fms_special
  import fms_pkg::*;
(
  input  fcls_e             zc,
  input  fcls_e             xc,
  input  fcls_e             yc,
  input  logic              xs,
  input  logic              ys,
  input  logic [WORD_W-1:0] zw,
  input  logic [WORD_W-1:0] xw,
  input  logic [WORD_W-1:0] yw,
  output logic              hit,
  output logic [WORD_W-1:0] word,
  output logic              inv
);
  localparam logic [WORD_W-1:0] QBIT = WORD_W'(1) << (FRAC_W - 1);
  localparam logic [WORD_W-1:0] INF_MAG = {1'b0, {EF_W{1'b1}}, {FRAC_W{1'b0}}};

  logic x_inf, y_inf, x_zero, y_zero;
  assign x_inf  = (xc == C_INF);
  assign y_inf  = (yc == C_INF);
  assign x_zero = (xc == C_ZERO);
  assign y_zero = (yc == C_ZERO);

  always_comb begin
    hit  = 1'b1;
    inv  = 1'b0;
    word = '0;
    if (zc == C_SNAN) begin
      inv  = 1'b1;
      word = zw | QBIT;
    end else if (yc == C_SNAN && xc != C_SNAN) begin
      inv  = 1'b1;
      word = yw | QBIT;
    end else if (xc == C_SNAN) begin
      inv  = 1'b1;
      word = xw | QBIT;
    end else if (yc == C_QNAN && xc != C_QNAN) begin
      word = yw;
    end else if (xc == C_QNAN) begin
      word = xw;
    end else if (zc == C_QNAN) begin
      word = zw;
    end else if ((x_inf && y_zero) || (x_zero && y_inf)) begin
      inv  = 1'b1;
      word = DEF_NAN;
    end else if (x_inf || y_inf) begin
      word = INF_MAG | {xs ^ ys, {(WORD_W-1){1'b0}}};
    end else if (x_zero || y_zero || zc == C_INF) begin
      word = zw;
    end else begin
      hit  = 1'b0;
    end
  end
endmodule

// File: rtl/fms_mul.sv
module fms_mul
  import fms_pkg::*;
(
  input  logic [MAN_W-1:0] xm,
  input  logic [MAN_W-1:0] ym,
  output logic [EXT_W-1:0] pm,
  output logic             ptop
);
  localparam int HW = WORD_W / 2;

  logic [WORD_W-1:0]   aj, bj;
  logic [HW-1:0]       ah [2];
  logic [HW-1:0]       bh [2];
  logic [WORD_W-1:0]   pp [4];
  logic [2*WORD_W-1:0] full;
  logic [WORD_W-1:0]   hi;

  assign aj = {xm, {(WORD_W-MAN_W){1'b0}}};
  assign bj = {ym, {(WORD_W-MAN_W){1'b0}}};

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign ah[h] = aj[h*HW +: HW];
    assign bh[h] = bj[h*HW +: HW];
  end

  for (genvar i = 0; i < 2; i++) begin : g_row
    for (genvar j = 0; j < 2; j++) begin : g_col
      assign pp[i*2+j] = ah[i] * bh[j];
    end
  end

  always_comb begin
    full = '0;
    for (int i = 0; i < 2; i++)
      for (int j = 0; j < 2; j++)
        full = full + ({{WORD_W{1'b0}}, pp[i*2+j]} << (HW * (i + j)));
    hi = full[2*WORD_W-1:WORD_W] | {{(WORD_W-1){1'b0}}, |full[WORD_W-1:0]};
    ptop = hi[WORD_W-1];
    if (ptop)
      pm = hi[WORD_W-1 -: EXT_W] | {{(EXT_W-1){1'b0}}, |hi[WORD_W-EXT_W-1:0]};
    else
      pm = hi[WORD_W-2 -: EXT_W] | {{(EXT_W-1){1'b0}}, |hi[WORD_W-EXT_W-2:0]};
  end
endmodule

// File: rtl/fms_addnorm.sv
module fms_addnorm
  import fms_pkg::*;
(
  input  logic                   zs,
  input  logic signed [XE_W-1:0] ze,
  input  logic [MAN_W-1:0]       zm,
  input  logic                   z_zero,
  input  logic                   rs,
  input  logic signed [XE_W-1:0] re,
  input  logic [EXT_W-1:0]       rm,
  output logic                   sgn,
  output logic signed [XE_W-1:0] ex,
  output logic [EXT_W-1:0]       sig,
  output logic                   is_zero
);
  function automatic logic [EXT_W-1:0] shr_sticky(input logic [EXT_W-1:0] v, input int d);
    logic [EXT_W-1:0] ones;
    logic [EXT_W-1:0] lost;
    ones = '1;
    if (d >= EXT_W) return {{(EXT_W-1){1'b0}}, |v};
    lost = v & ~(ones << d);
    return (v >> d) | {{(EXT_W-1){1'b0}}, |lost};
  endfunction

  logic [EXT_W-1:0] zx, a, b, diff;
  logic [EXT_W:0]   sum;
  logic [4:0]       lz;
  int               dz, ealn, adj;

  assign zx = {zm, 3'b000};

  always_comb begin
    dz   = int'(ze) - int'(re);
    a    = zx;
    b    = rm;
    ealn = int'(re);
    if (z_zero) begin
      a = '0;
    end else if (dz > 0) begin
      b    = shr_sticky(rm, dz);
      ealn = int'(ze);
    end else begin
      a = shr_sticky(zx, -dz);
    end

    sum     = '0;
    diff    = '0;
    lz      = '0;
    adj     = 0;
    is_zero = 1'b0;
    sgn     = zs;
    if (zs == rs) begin
      sum = {1'b0, a} + {1'b0, b};
      if (sum[EXT_W]) begin
        sig = sum[EXT_W:1] | {{(EXT_W-1){1'b0}}, sum[0]};
        adj = 1;
      end else begin
        sig = sum[EXT_W-1:0];
      end
    end else begin
      if (a >= b) diff = a - b;
      else begin
        diff = b - a;
        sgn  = rs;
      end
      is_zero = (diff == '0);
      lz  = lzc_ext(diff);
      sig = is_zero ? '0 : (diff << lz);
      adj = is_zero ? 0 : -int'(lz);
    end
    ex = XE_W'(ealn + adj);
  end
endmodule

// File: rtl/fms_core.sv
module fms_core
  import fms_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [31:0]            opnd_z,
  input  logic [31:0]            opnd_x,
  input  logic [31:0]            opnd_y,
  input  logic [1:0]             rmode,
  output logic                   out_valid,
  output logic                   out_final,
  output logic [31:0]            out_word,
  output logic                   out_invalid,
  output logic                   out_sign,
  output logic signed [9:0]      out_exp,
  output logic [26:0]            out_sig
);
  localparam logic [1:0] RM_DOWN = 2'b11;

  fcls_e                  zc, xc, yc;
  logic                   zs, xs, ys;
  logic signed [XE_W-1:0] ze, xe, ye, re, ae;
  logic [MAN_W-1:0]       zm, xm, ym;
  logic [EXT_W-1:0]       pm, asig;
  logic                   ptop, asgn, azero;
  logic                   sp_hit, sp_inv;
  logic [WORD_W-1:0]      sp_word;

  fms_unpack u_unp_z (.word(opnd_z), .cls(zc), .sgn(zs), .ex(ze), .man(zm));
  fms_unpack u_unp_x (.word(opnd_x), .cls(xc), .sgn(xs), .ex(xe), .man(xm));
  fms_unpack u_unp_y (.word(opnd_y), .cls(yc), .sgn(ys), .ex(ye), .man(ym));

  fms_special u_spec (
    .zc(zc), .xc(xc), .yc(yc), .xs(xs), .ys(ys),
    .zw(opnd_z), .xw(opnd_x), .yw(opnd_y),
    .hit(sp_hit), .word(sp_word), .inv(sp_inv)
  );

  fms_mul u_mul (.xm(xm), .ym(ym), .pm(pm), .ptop(ptop));

  assign re = XE_W'(int'(xe) + int'(ye) + int'(ptop));

  fms_addnorm u_add (
    .zs(zs), .ze(ze), .zm(zm), .z_zero(zc == C_ZERO),
    .rs(~(xs ^ ys)), .re(re), .rm(pm),
    .sgn(asgn), .ex(ae), .sig(asig), .is_zero(azero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_final   <= 1'b0;
      out_word    <= '0;
      out_invalid <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_sig     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_invalid <= sp_hit & sp_inv;
        out_final   <= sp_hit | azero;
        out_word    <= sp_hit ? sp_word :
                       azero  ? {rmode == RM_DOWN, {(WORD_W-1){1'b0}}} : '0;
        out_sign    <= (sp_hit | azero) ? 1'b0 : asgn;
        out_exp     <= (sp_hit | azero) ? '0 : ae;
        out_sig     <= (sp_hit | azero) ? '0 : asig;
      end
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  hidden_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_final) |-> out_sig[EXT_W-1]);
  // R5
  inv_final_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> out_final);
  // R3
  nan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_final && out_invalid && out_word[30:23] == 8'hFF)
      |-> out_word[22]);
endmodule

// File: tb/fms_core_tb.sv
module fms_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] opnd_z = '0, opnd_x = '0, opnd_y = '0;
  logic [1:0]  rmode = 2'b00;
  logic        out_valid, out_final, out_invalid, out_sign;
  logic [31:0] out_word;
  logic signed [9:0] out_exp;
  logic [26:0] out_sig;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fms_core dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .opnd_z(opnd_z), .opnd_x(opnd_x), .opnd_y(opnd_y), .rmode(rmode),
    .out_valid(out_valid), .out_final(out_final), .out_word(out_word),
    .out_invalid(out_invalid), .out_sign(out_sign), .out_exp(out_exp),
    .out_sig(out_sig)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0:  pick = 32'h0000_0000;
      1:  pick = 32'h8000_0000;
      2:  pick = 32'h3F80_0000;
      3:  pick = 32'hBFC0_0000;
      4:  pick = 32'h4040_0000;
      5:  pick = 32'h0D80_0000;
      6:  pick = 32'h0000_0003;
      7:  pick = 32'h8040_0000;
      8:  pick = 32'h7E80_0000;
      9:  pick = 32'h3F7F_FFFF;
      10: pick = 32'h7F80_0000;
      11: pick = 32'hFF80_0000;
      12: pick = 32'h7FC0_0001;
      13: pick = 32'h7F80_0005;
      14: pick = 32'h4049_0FDB;
      default: pick = 32'hC120_0000;
    endcase
  endfunction

  // 0 zero, 1 finite nonzero, 2 inf, 3 quiet NaN, 4 signalling NaN
  function automatic int kind(input logic [31:0] w);
    if (w[30:23] == 8'hFF) begin
      if (w[22:0] == 0) return 2;
      return w[22] ? 3 : 4;
    end
    return (w[30:0] == 0) ? 0 : 1;
  endfunction

  function automatic real to_real(input logic [31:0] w);
    real v;
    if (w[30:23] == 0) v = real'(w[22:0]) * 2.0 ** (-149.0);
    else v = real'(int'(w[22:0]) + 8388608) * 2.0 ** real'(int'(w[30:23]) - 150);
    return w[31] ? -v : v;
  endfunction

  task automatic model_special(input logic [31:0] z, x, y,
                               output bit hit, output logic [31:0] w, output bit inv);
    int kz, kx, ky;
    kz = kind(z); kx = kind(x); ky = kind(y);
    hit = 1; inv = 0; w = '0;
    if (kz == 4) begin inv = 1; w = z | 32'h0040_0000; end
    else if (ky == 4 && kx != 4) begin inv = 1; w = y | 32'h0040_0000; end
    else if (kx == 4) begin inv = 1; w = x | 32'h0040_0000; end
    else if (ky == 3 && kx != 3) w = y;
    else if (kx == 3) w = x;
    else if (kz == 3) w = z;
    else if ((kx == 2 && ky == 0) || (kx == 0 && ky == 2)) begin inv = 1; w = 32'h7FC0_0000; end
    else if (kx == 2 || ky == 2) w = {x[31] ^ y[31], 31'h7F80_0000};
    else if (kx == 0 || ky == 0 || kz == 2) w = z;
    else hit = 0;
  endtask

  task automatic issue(input logic [31:0] z, x, y, input logic [1:0] rm);
    @(negedge clk);
    opnd_z = z; opnd_x = x; opnd_y = y; rmode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_arith(input string req, input logic [31:0] z, x, y,
                             input logic s, input int e, input logic [26:0] m);
    issue(z, x, y, 2'b00);
    chk(out_valid && !out_final, req, "final", longint'(out_final), 0);
    chk(out_sign == s, req, "sign", longint'(out_sign), longint'(s));
    chk(int'(out_exp) == e, req, "exp", longint'(int'(out_exp)), longint'(e));
    chk(out_sig == m, req, "sig", longint'(out_sig), longint'(m));
  endtask

  task automatic check_word(input string req, input logic [31:0] z, x, y,
                            input logic [1:0] rm, input logic [31:0] w, input bit inv);
    issue(z, x, y, rm);
    chk(out_valid && out_final, req, "final", longint'(out_final), 1);
    chk(out_word == w, req, "word", longint'(out_word), longint'(w));
    chk(out_invalid == inv, req, "invalid", longint'(out_invalid), longint'(inv));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "valid in reset", longint'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 0, "R1", "valid after reset", longint'(out_valid), 0);

    // R1: strobe then idle cycle
    issue(32'h4040_0000, 32'h3F80_0000, 32'h3F80_0000, 2'b00);
    chk(out_valid == 1, "R1", "valid after strobe", longint'(out_valid), 1);
    @(negedge clk);
    chk(out_valid == 0, "R1", "valid idle", longint'(out_valid), 0);

    // R2 and R3 priority
    check_word("R2", 32'h7F80_0001, 32'h7F80_0002, 32'h7F80_0003, 2'b00, 32'h7FC0_0001, 1);
    check_word("R3", 32'h3F80_0000, 32'h7FC0_0007, 32'h7F80_0003, 2'b00, 32'h7FC0_0003, 1);
    check_word("R3", 32'h3F80_0000, 32'h7F80_0002, 32'h7F80_0003, 2'b00, 32'h7FC0_0002, 1);
    check_word("R3", 32'h3F80_0000, 32'h7FC0_0004, 32'h7FC0_0005, 2'b00, 32'h7FC0_0004, 0);
    check_word("R4", 32'h7FC0_0009, 32'h7F80_0000, 32'h0000_0000, 2'b00, 32'h7FC0_0009, 0);
    check_word("R5", 32'h3F80_0000, 32'h0000_0000, 32'hFF80_0000, 2'b00, 32'h7FC0_0000, 1);
    check_word("R6", 32'h7F80_0000, 32'hFF80_0000, 32'h4040_0000, 2'b00, 32'hFF80_0000, 0);
    check_word("R7", 32'hFF80_0000, 32'h0000_0000, 32'h4040_0000, 2'b00, 32'hFF80_0000, 0);
    check_word("R7", 32'h7F80_0000, 32'h4040_0000, 32'h4040_0000, 2'b00, 32'h7F80_0000, 0);

    // R8: 2^-127 (denormal) * 2^127 subtracted from zero gives -1.0
    check_arith("R8", 32'h0000_0000, 32'h0040_0000, 32'h7F00_0000, 1'b1, 0, 27'h400_0000);
    // R10: 3 - 1 = 2 (opposite signs), -1 - 1 = -2 (same signs, carry)
    check_arith("R10", 32'h4040_0000, 32'h3F80_0000, 32'h3F80_0000, 1'b0, 1, 27'h400_0000);
    check_arith("R10", 32'hBF80_0000, 32'h3F80_0000, 32'h3F80_0000, 1'b1, 1, 27'h400_0000);
    // R12: saturated alignment keeps only sticky
    check_arith("R12", 32'h3F80_0000, 32'h0D80_0000, 32'h3F80_0000, 1'b0, -1, 27'h7FF_FFFE);
    check_arith("R12", 32'hBF80_0000, 32'h0D80_0000, 32'h3F80_0000, 1'b1, 0, 27'h400_0001);
    // R11: exact cancellation
    check_word("R11", 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 2'b00, 32'h0000_0000, 0);
    check_word("R11", 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 2'b11, 32'h8000_0000, 0);
    check_word("R11", 32'h4040_0000, 32'h3FC0_0000, 32'h4000_0000, 2'b10, 32'h0000_0000, 0);

    // Sweep over all class pairs: R2..R9
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int k = 0; k < 16; k++) begin
          logic [31:0] z, x, y, w;
          bit hit, inv;
          real rz, rp, rref, got, tol;
          z = pick(i); x = pick(j); y = pick(k);
          model_special(z, x, y, hit, w, inv);
          issue(z, x, y, 2'b00);
          if (hit) begin
            chk(out_final && out_word == w && out_invalid == inv, "R3",
                "special word", longint'(out_word), longint'(w));
          end else begin
            rz = to_real(z);
            rp = to_real(x) * to_real(y);
            rref = rz - rp;
            if (rref == 0.0) begin
              chk(out_final && out_word == 32'h0 && !out_invalid, "R11",
                  "zero word", longint'(out_word), 0);
            end else begin
              got = real'(out_sig) * 2.0 ** real'(int'(out_exp) - 26);
              if (out_sign) got = -got;
              tol = ((rz < 0 ? -rz : rz) > (rp < 0 ? -rp : rp) ? (rz < 0 ? -rz : rz)
                                                              : (rp < 0 ? -rp : rp)) * 2.0 ** (-22.0);
              checks++;
              if (out_final || !out_sig[26] || out_invalid ||
                  (got - rref > tol) || (rref - got > tol)) begin
                errors++;
                $display("FAIL R9 value z=%h x=%h y=%h: actual %g expected %g",
                         z, x, y, got, rref);
              end
            end
          end
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule